// File: doc/BRIEF.md
# Low-power mode controller

This block steps a device between run and three power-saving modes of increasing depth. The processor asks for a low-power period with a one-cycle request and a two-bit mode selector. The controller then drops the set of clock, oscillator and regulator enables that belongs to that mode. In each mode it listens only to the wake sources that mode allows.

Sleep gates only the processor clock. Stop shuts every core clock and all three clock generators while the regulator stays up. Standby also switches the core regulator off. A stop wake first restarts the internal RC oscillator and waits for its ready flag before clocks come back. A standby wake does not resume: it issues a one-cycle system reset and then returns to run.

A cause register, kept outside the core domain, records which source ended the latest low-power period. Software clears it with a clear strobe.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in run. cpu_clk_en, per_clk_en, pll_en, hsi_en, hse_en and core_reg_on are 1. core_reg_lp and sys_rst_req are 0, and wake_cause is 0.
- R2: In run, lp_req with lp_mode 2'b00 or 2'b11 enters sleep on the next clock. In sleep only cpu_clk_en is 0; every other enable stays as in run.
- R3: In sleep, irq_any returns the block to run on the next clock and loads wake_cause with 1. The stop wake lines have no effect in sleep.
- R4: In run, lp_req with lp_mode 2'b01 enters stop on the next clock. In stop all clock and oscillator enables are 0 and core_reg_on is 1. core_reg_lp equals the value stop_reg_lp had at the request.
- R5: Stop is left only on ext_line, pvd_out, rtc_evt, i2c_wake or usart_wake; irq_any has no effect in stop. When several fire together, the lowest cause code wins. The codes are: any ext_line 2, pvd_out 3, rtc_evt 4, i2c_wake 5, usart_wake 6.
- R6: After a stop wake, only hsi_en and core_reg_on are 1 until hsi_ready is sampled high. On the clock that samples hsi_ready high, the block returns to run with all enables on.
- R7: In run, lp_req with lp_mode 2'b10 enters standby on the next clock. In standby every enable, including core_reg_on, is 0. irq_any and the stop wake lines have no effect in standby.
- R8: In standby, rst_pin, wdg_rst or rtc_evt leaves on the next clock into a reset cycle. In that cycle sys_rst_req, hsi_en and core_reg_on are 1. The next cycle is run, with sys_rst_req back to 0.
- R9: wake_pin passes a two-stage synchronizer and edge detector. A rising edge ends standby on the third clock after the pin rises. A pin that is already high when standby is entered does not wake the block.
- R10: Standby cause codes are rst_pin 7, wdg_rst 8, wake_pin 9 and rtc_evt 4, with priority in that order. cause_clr sets wake_cause to 0 on the next clock, and a wake load in the same cycle takes precedence over the clear.
- R11: lp_req has no effect while the block is in any state other than run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_req | input | 1 | Low-power request pulse from the processor |
| lp_mode | input | 2 | Requested mode: 00/11 sleep, 01 stop, 10 standby |
| stop_reg_lp | input | 1 | Put the regulator in low-power state during stop |
| irq_any | input | 1 | Any enabled interrupt or event (sleep wake) |
| ext_line | input | N_EXT | External interrupt lines (stop wake) |
| pvd_out | input | 1 | Voltage detector output (stop wake) |
| rtc_evt | input | 1 | RTC event (stop and standby wake) |
| i2c_wake | input | 1 | I2C wake request (stop wake) |
| usart_wake | input | 1 | USART wake request (stop wake) |
| rst_pin | input | 1 | External reset pin asserted (standby wake) |
| wdg_rst | input | 1 | Independent watchdog reset (standby wake) |
| wake_pin | input | 1 | Asynchronous wake-up pin, rising edge (standby wake) |
| hsi_ready | input | 1 | Internal RC oscillator is stable |
| cause_clr | input | 1 | Software clear of the wake cause |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable |
| hsi_en | output | 1 | Internal RC oscillator enable |
| hse_en | output | 1 | External crystal oscillator enable |
| core_reg_on | output | 1 | Core regulator on |
| core_reg_lp | output | 1 | Core regulator low-power state |
| sys_rst_req | output | 1 | One-cycle system reset request after standby |
| wake_cause | output | 4 | Code of the last source that ended a low-power period |

## Verification
All enables are decoded from a registered state. A request, a sleep or stop wake source, a standby reset source, or hsi_ready therefore moves the outputs one clock after the edge that samples it. The wake pin takes three clocks, because of its synchronizer and edge register.

The bench drives every input just after a falling edge and reads the outputs at a later falling edge, counted from the expected edge. For the wake pin, it also checks that the block is still in standby one and two falling edges after the pin rises. The wake cause is read on the same sample as the return to run, because it is loaded by the edge that changes state.

// File: rtl/lpm_pkg.sv
// Shared types and codes for the low-power mode controller.
// Assumes: cause codes fit in CAUSE_W bits; mode selector is two bits wide.
package lpm_pkg;

    localparam int CAUSE_W = 4;

    // Requested mode encodings on the mode selector.
    localparam logic [1:0] MD_SLEEP     = 2'b00;
    localparam logic [1:0] MD_STOP      = 2'b01;
    localparam logic [1:0] MD_STBY      = 2'b10;
    localparam logic [1:0] MD_SLEEP_ALT = 2'b11;

    // Wake cause codes.
    localparam logic [CAUSE_W-1:0] WC_NONE  = 4'd0;
    localparam logic [CAUSE_W-1:0] WC_IRQ   = 4'd1;
    localparam logic [CAUSE_W-1:0] WC_LINE  = 4'd2;
    localparam logic [CAUSE_W-1:0] WC_PVD   = 4'd3;
    localparam logic [CAUSE_W-1:0] WC_RTC   = 4'd4;
    localparam logic [CAUSE_W-1:0] WC_I2C   = 4'd5;
    localparam logic [CAUSE_W-1:0] WC_USART = 4'd6;
    localparam logic [CAUSE_W-1:0] WC_RSTP  = 4'd7;
    localparam logic [CAUSE_W-1:0] WC_WDG   = 4'd8;
    localparam logic [CAUSE_W-1:0] WC_PIN   = 4'd9;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_STOP,
        ST_WAKE,
        ST_STBY,
        ST_RSTO
    } lpm_state_e;

    // Enable and gate bundle driven by the sequencer.
    typedef struct packed {
        logic cpu_clk;
        logic per_clk;
        logic pll;
        logic hsi;
        logic hse;
        logic reg_on;
        logic reg_lp;
        logic rst_req;
    } lpm_ctl_t;

endpackage

// File: rtl/lpm_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops and flags one
// cycle when the synchronized level rises.
// Assumes: STAGES >= 2; the pin stays high long enough to be sampled.
module lpm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    localparam int LAST = STAGES;

    logic [LAST:0] shr;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr <= '0;
        end else begin
            shr <= {shr[LAST-1:0], pin};
        end
    end

    assign rise = shr[LAST-1] & ~shr[LAST];

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R9

endmodule

// File: rtl/lpm_wake_sel.sv
// Priority encoders for the wake sources of stop and of standby.
// Assumes: inputs are already synchronous to the controller clock.
module lpm_wake_sel
    import lpm_pkg::*;
#(
    parameter int N_EXT = 16
) (
    input  logic [N_EXT-1:0]   ext_line,
    input  logic               pvd_out,
    input  logic               rtc_evt,
    input  logic               i2c_wake,
    input  logic               usart_wake,
    input  logic               rst_pin,
    input  logic               wdg_rst,
    input  logic               pin_rise,
    output logic               stop_hit,
    output logic [CAUSE_W-1:0] stop_code,
    output logic               stby_hit,
    output logic [CAUSE_W-1:0] stby_code
);

    logic [N_EXT-1:0] line_or;

    // Ripple OR over the external lines, one stage per line.
    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_or
            if (gi == 0) begin : g_first
                assign line_or[gi] = ext_line[gi];
            end else begin : g_rest
                assign line_or[gi] = line_or[gi-1] | ext_line[gi];
            end
        end
    endgenerate

    // Stop wake priority: lines, voltage detector, RTC, I2C, USART.
    always_comb begin
        stop_hit  = 1'b1;
        stop_code = WC_NONE;
        if (line_or[N_EXT-1])  stop_code = WC_LINE;
        else if (pvd_out)      stop_code = WC_PVD;
        else if (rtc_evt)      stop_code = WC_RTC;
        else if (i2c_wake)     stop_code = WC_I2C;
        else if (usart_wake)   stop_code = WC_USART;
        else                   stop_hit  = 1'b0;
    end

    // Standby wake priority: reset pin, watchdog, wake pin, RTC.
    always_comb begin
        stby_hit  = 1'b1;
        stby_code = WC_NONE;
        if (rst_pin)           stby_code = WC_RSTP;
        else if (wdg_rst)      stby_code = WC_WDG;
        else if (pin_rise)     stby_code = WC_PIN;
        else if (rtc_evt)      stby_code = WC_RTC;
        else                   stby_hit  = 1'b0;
    end

endmodule

// File: rtl/lpm_seq.sv
// Mode sequencer: moves between run, sleep, stop, oscillator restart,
// standby and a reset cycle, and decodes the enables from its state.
// Assumes: lp_req is a pulse from the processor; wake hits are synchronous.
module lpm_seq
    import lpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_req,
    input  logic [1:0]         mode,
    input  logic               stop_lp_reg,
    input  logic               irq_any,
    input  logic               stop_hit,
    input  logic [CAUSE_W-1:0] stop_code,
    input  logic               stby_hit,
    input  logic [CAUSE_W-1:0] stby_code,
    input  logic               hsi_ready,
    output lpm_ctl_t           ctl,
    output logic               cause_load,
    output logic [CAUSE_W-1:0] cause_val
);

    lpm_state_e state, nxt;
    logic       stop_lp_q;
    logic       req_sleep, req_stop, req_stby;

    assign req_stop  = lp_req && (mode == MD_STOP);
    assign req_stby  = lp_req && (mode == MD_STBY);
    assign req_sleep = lp_req && (mode == MD_SLEEP || mode == MD_SLEEP_ALT);

    // State register and capture of the stop regulator choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            stop_lp_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RUN && req_stop) stop_lp_q <= stop_lp_reg;
        end
    end

    // Next state and the cause to record on a wake transition.
    always_comb begin
        nxt        = state;
        cause_load = 1'b0;
        cause_val  = WC_NONE;
        case (state)
            ST_RUN: begin
                if (req_stop)       nxt = ST_STOP;
                else if (req_stby)  nxt = ST_STBY;
                else if (req_sleep) nxt = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (irq_any) begin
                    nxt        = ST_RUN;
                    cause_load = 1'b1;
                    cause_val  = WC_IRQ;
                end
            end
            ST_STOP: begin
                if (stop_hit) begin
                    nxt        = ST_WAKE;
                    cause_load = 1'b1;
                    cause_val  = stop_code;
                end
            end
            ST_WAKE: begin
                if (hsi_ready) nxt = ST_RUN;
            end
            ST_STBY: begin
                if (stby_hit) begin
                    nxt        = ST_RSTO;
                    cause_load = 1'b1;
                    cause_val  = stby_code;
                end
            end
            ST_RSTO: nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    // Decode of enables and gates per state.
    always_comb begin
        ctl = '0;
        case (state)
            ST_RUN: begin
                ctl.cpu_clk = 1'b1;
                ctl.per_clk = 1'b1;
                ctl.pll     = 1'b1;
                ctl.hsi     = 1'b1;
                ctl.hse     = 1'b1;
                ctl.reg_on  = 1'b1;
            end
            ST_SLEEP: begin
                ctl.per_clk = 1'b1;
                ctl.pll     = 1'b1;
                ctl.hsi     = 1'b1;
                ctl.hse     = 1'b1;
                ctl.reg_on  = 1'b1;
            end
            ST_STOP: begin
                ctl.reg_on = 1'b1;
                ctl.reg_lp = stop_lp_q;
            end
            ST_WAKE: begin
                ctl.hsi    = 1'b1;
                ctl.reg_on = 1'b1;
            end
            ST_RSTO: begin
                ctl.hsi     = 1'b1;
                ctl.reg_on  = 1'b1;
                ctl.rst_req = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    AST_SLEEP_GATES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && req_sleep) |=>
        (!ctl.cpu_clk && ctl.per_clk && ctl.pll && ctl.hsi && ctl.hse)); // R2

    AST_SLEEP_WAITS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !irq_any) |=> !ctl.cpu_clk); // R3

    AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && req_stop) |=>
        (!ctl.per_clk && !ctl.pll && !ctl.hsi && !ctl.hse && ctl.reg_on
         && ctl.reg_lp == $past(stop_lp_reg))); // R4

    AST_HSI_BEFORE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && !hsi_ready) |=> (!ctl.cpu_clk && ctl.hsi)); // R6

    AST_STBY_REG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && req_stby) |=> (!ctl.reg_on && !ctl.hsi)); // R7

    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rst_req |=> (!ctl.rst_req && ctl.cpu_clk)); // R8

    AST_REQ_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.cpu_clk && !ctl.rst_req && state != ST_WAKE && lp_req
         && !irq_any && !stop_hit && !stby_hit) |=> !ctl.cpu_clk); // R11

endmodule

// File: rtl/lpm_cause.sv
// Wake cause register; loaded on each wake transition, cleared by software.
// Assumes: a load and a clear in the same cycle keep the new cause.
module lpm_cause
    import lpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CAUSE_W-1:0] val,
    input  logic               clr,
    output logic [CAUSE_W-1:0] cause
);

    // Hold the last wake cause until replaced or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= WC_NONE;
        end else if (load) begin
            cause <= val;
        end else if (clr) begin
            cause <= WC_NONE;
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> (cause == WC_NONE)); // R10

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cause == $past(val))); // R10

endmodule

// File: rtl/lpm_ctrl.sv
// Top of the low-power mode controller: wake pin synchronizer, wake source
// encoders, mode sequencer and wake cause register.
// Assumes: all inputs except wake_pin are synchronous to clk.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_EXT       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_req,
    input  logic [1:0]         lp_mode,
    input  logic               stop_reg_lp,
    input  logic               irq_any,
    input  logic [N_EXT-1:0]   ext_line,
    input  logic               pvd_out,
    input  logic               rtc_evt,
    input  logic               i2c_wake,
    input  logic               usart_wake,
    input  logic               rst_pin,
    input  logic               wdg_rst,
    input  logic               wake_pin,
    input  logic               hsi_ready,
    input  logic               cause_clr,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               pll_en,
    output logic               hsi_en,
    output logic               hse_en,
    output logic               core_reg_on,
    output logic               core_reg_lp,
    output logic               sys_rst_req,
    output logic [CAUSE_W-1:0] wake_cause
);

    logic               pin_rise;
    logic               stop_hit, stby_hit;
    logic [CAUSE_W-1:0] stop_code, stby_code;
    logic               cause_load;
    logic [CAUSE_W-1:0] cause_val;
    lpm_ctl_t           ctl;

    lpm_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (wake_pin),
        .rise  (pin_rise)
    );

    lpm_wake_sel #(.N_EXT(N_EXT)) i_sel (
        .ext_line   (ext_line),
        .pvd_out    (pvd_out),
        .rtc_evt    (rtc_evt),
        .i2c_wake   (i2c_wake),
        .usart_wake (usart_wake),
        .rst_pin    (rst_pin),
        .wdg_rst    (wdg_rst),
        .pin_rise   (pin_rise),
        .stop_hit   (stop_hit),
        .stop_code  (stop_code),
        .stby_hit   (stby_hit),
        .stby_code  (stby_code)
    );

    lpm_seq i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .lp_req      (lp_req),
        .mode        (lp_mode),
        .stop_lp_reg (stop_reg_lp),
        .irq_any     (irq_any),
        .stop_hit    (stop_hit),
        .stop_code   (stop_code),
        .stby_hit    (stby_hit),
        .stby_code   (stby_code),
        .hsi_ready   (hsi_ready),
        .ctl         (ctl),
        .cause_load  (cause_load),
        .cause_val   (cause_val)
    );

    lpm_cause i_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cause_load),
        .val   (cause_val),
        .clr   (cause_clr),
        .cause (wake_cause)
    );

    assign cpu_clk_en  = ctl.cpu_clk;
    assign per_clk_en  = ctl.per_clk;
    assign pll_en      = ctl.pll;
    assign hsi_en      = ctl.hsi;
    assign hse_en      = ctl.hse;
    assign core_reg_on = ctl.reg_on;
    assign core_reg_lp = ctl.reg_lp;
    assign sys_rst_req = ctl.rst_req;

endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;

    localparam int N_EXT = 16;
    localparam logic [7:0] C_RUN   = 8'b1111_1100;
    localparam logic [7:0] C_SLEEP = 8'b0111_1100;
    localparam logic [7:0] C_WAKE  = 8'b0001_0100;
    localparam logic [7:0] C_STBY  = 8'b0000_0000;
    localparam logic [7:0] C_RSTO  = 8'b0001_0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp_req = 1'b0;
    logic [1:0] lp_mode = 2'b00;
    logic stop_reg_lp = 1'b0;
    logic irq_any = 1'b0;
    logic [N_EXT-1:0] ext_line = '0;
    logic pvd_out = 1'b0, rtc_evt = 1'b0, i2c_wake = 1'b0, usart_wake = 1'b0;
    logic rst_pin = 1'b0, wdg_rst = 1'b0, wake_pin = 1'b0;
    logic hsi_ready = 1'b0, cause_clr = 1'b0;
    logic cpu_clk_en, per_clk_en, pll_en, hsi_en, hse_en;
    logic core_reg_on, core_reg_lp, sys_rst_req;
    logic [3:0] wake_cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    lpm_ctrl #(.N_EXT(N_EXT), .SYNC_STAGES(2)) i_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .lp_mode(lp_mode),
        .stop_reg_lp(stop_reg_lp), .irq_any(irq_any), .ext_line(ext_line),
        .pvd_out(pvd_out), .rtc_evt(rtc_evt), .i2c_wake(i2c_wake),
        .usart_wake(usart_wake), .rst_pin(rst_pin), .wdg_rst(wdg_rst),
        .wake_pin(wake_pin), .hsi_ready(hsi_ready), .cause_clr(cause_clr),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pll_en(pll_en),
        .hsi_en(hsi_en), .hse_en(hse_en), .core_reg_on(core_reg_on),
        .core_reg_lp(core_reg_lp), .sys_rst_req(sys_rst_req),
        .wake_cause(wake_cause)
    );

    function automatic logic [7:0] ctl_now();
        return {cpu_clk_en, per_clk_en, pll_en, hsi_en, hse_en,
                core_reg_on, core_reg_lp, sys_rst_req};
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic enter(input logic [1:0] m, input logic lp);
        lp_req = 1'b1; lp_mode = m; stop_reg_lp = lp;
        tick(1);
        lp_req = 1'b0; stop_reg_lp = 1'b0;
    endtask

    task automatic set_stop_src(input int s, input logic v);
        if (s < N_EXT) ext_line[s] = v;
        else if (s == N_EXT) pvd_out = v;
        else if (s == N_EXT + 1) rtc_evt = v;
        else if (s == N_EXT + 2) i2c_wake = v;
        else usart_wake = v;
    endtask

    function automatic int stop_code(input int s);
        if (s < N_EXT) return 2;
        if (s == N_EXT) return 3;
        if (s == N_EXT + 1) return 4;
        if (s == N_EXT + 2) return 5;
        return 6;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1", ctl_now(), C_RUN, "reset enables");
        chk("R1", wake_cause, 0, "reset cause");

        // Sleep for both sleep encodings.
        for (int m = 0; m < 4; m += 3) begin
            enter(2'(m), 1'b0);
            chk("R2", ctl_now(), C_SLEEP, "sleep enables");
            ext_line = '1; pvd_out = 1'b1; rtc_evt = 1'b1; tick(1);
            ext_line = '0; pvd_out = 1'b0; rtc_evt = 1'b0;
            chk("R3", ctl_now(), C_SLEEP, "stop sources ignored in sleep");
            enter(2'b01, 1'b0);
            chk("R11", ctl_now(), C_SLEEP, "request ignored in sleep");
            irq_any = 1'b1; tick(1); irq_any = 1'b0;
            chk("R3", ctl_now(), C_RUN, "irq wakes sleep");
            chk("R3", wake_cause, 1, "sleep cause");
        end

        // Stop: every source, both regulator choices.
        for (int lp = 0; lp < 2; lp++) begin
            for (int s = 0; s < N_EXT + 4; s++) begin
                enter(2'b01, 1'(lp));
                chk("R4", ctl_now(), {6'b000001, 1'(lp), 1'b0}, "stop enables");
                irq_any = 1'b1; tick(1); irq_any = 1'b0;
                chk("R5", ctl_now(), {6'b000001, 1'(lp), 1'b0}, "irq ignored in stop");
                set_stop_src(s, 1'b1); tick(1); set_stop_src(s, 1'b0);
                chk("R6", ctl_now(), C_WAKE, "restart waits oscillator");
                chk("R5", wake_cause, stop_code(s), "stop cause");
                tick(2);
                chk("R6", ctl_now(), C_WAKE, "still waiting oscillator");
                hsi_ready = 1'b1; tick(1); hsi_ready = 1'b0;
                chk("R6", ctl_now(), C_RUN, "run after oscillator ready");
            end
        end

        // Stop priority.
        enter(2'b01, 1'b0);
        ext_line = 16'h8000; pvd_out = 1'b1; rtc_evt = 1'b1; usart_wake = 1'b1;
        tick(1);
        ext_line = '0; pvd_out = 1'b0; rtc_evt = 1'b0; usart_wake = 1'b0;
        chk("R5", wake_cause, 2, "line beats others");
        hsi_ready = 1'b1; tick(1); hsi_ready = 1'b0;
        enter(2'b01, 1'b0);
        pvd_out = 1'b1; usart_wake = 1'b1; tick(1);
        pvd_out = 1'b0; usart_wake = 1'b0;
        chk("R5", wake_cause, 3, "detector beats usart");
        hsi_ready = 1'b1; tick(1); hsi_ready = 1'b0;

        // Standby: reset pin, watchdog, wake pin, RTC.
        for (int s = 0; s < 4; s++) begin
            enter(2'b10, 1'b0);
            chk("R7", ctl_now(), C_STBY, "standby enables");
            ext_line = '1; irq_any = 1'b1; pvd_out = 1'b1; i2c_wake = 1'b1;
            tick(1);
            ext_line = '0; irq_any = 1'b0; pvd_out = 1'b0; i2c_wake = 1'b0;
            chk("R7", ctl_now(), C_STBY, "stop sources ignored in standby");
            enter(2'b00, 1'b0);
            chk("R11", ctl_now(), C_STBY, "request ignored in standby");
            if (s == 2) begin
                wake_pin = 1'b1;
                tick(2);
                chk("R9", ctl_now(), C_STBY, "pin still synchronizing");
                tick(1);
            end else begin
                rst_pin = (s == 0); wdg_rst = (s == 1); rtc_evt = (s == 3);
                tick(1);
                rst_pin = 1'b0; wdg_rst = 1'b0; rtc_evt = 1'b0;
            end
            chk("R8", ctl_now(), C_RSTO, "reset cycle");
            chk("R10", wake_cause, (s == 0) ? 7 : (s == 1) ? 8 : (s == 2) ? 9 : 4,
                "standby cause");
            tick(1);
            chk("R8", ctl_now(), C_RUN, "run after reset cycle");
            wake_pin = 1'b0;
            tick(3);
        end

        // Standby priority.
        enter(2'b10, 1'b0);
        rst_pin = 1'b1; wdg_rst = 1'b1; rtc_evt = 1'b1; tick(1);
        rst_pin = 1'b0; wdg_rst = 1'b0; rtc_evt = 1'b0;
        chk("R10", wake_cause, 7, "reset pin beats others");
        tick(1);
        enter(2'b10, 1'b0);
        wdg_rst = 1'b1; rtc_evt = 1'b1; tick(1);
        wdg_rst = 1'b0; rtc_evt = 1'b0;
        chk("R10", wake_cause, 8, "watchdog beats rtc");
        tick(1);

        // Wake pin already high at entry.
        wake_pin = 1'b1; tick(4);
        enter(2'b10, 1'b0);
        tick(6);
        chk("R9", ctl_now(), C_STBY, "high pin does not wake");
        wake_pin = 1'b0; tick(3);
        chk("R9", ctl_now(), C_STBY, "falling pin does not wake");
        wake_pin = 1'b1; tick(3);
        chk("R9", ctl_now(), C_RSTO, "rising pin wakes after three clocks");
        tick(1);
        wake_pin = 1'b0; tick(3);

        // Cause clear and load precedence.
        cause_clr = 1'b1; tick(1); cause_clr = 1'b0;
        chk("R10", wake_cause, 0, "clear empties cause");
        enter(2'b00, 1'b0);
        irq_any = 1'b1; cause_clr = 1'b1; tick(1);
        irq_any = 1'b0; cause_clr = 1'b0;
        chk("R10", wake_cause, 1, "load wins over clear");
        chk("R3", ctl_now(), C_RUN, "run after sleep wake");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule